// File: doc/BRIEF.md
# Video Memory Address Decoder with Nametable Folding

This block sits between a picture-processor core and the memories behind its 14-bit video address space. Each accepted request carries a 16-bit address, a write flag and a data byte. The block sends the request to one of three places. Pattern fetches go out on a synchronous character-ROM read port. Nametable accesses go to two internal 1 KiB RAMs. Palette accesses go to an internal 32-byte RAM. Addresses in the unused range, and addresses beyond the 14-bit space, reach no storage.

The four logical 1 KiB nametable windows fold onto the two physical RAMs. A plain mode pin picks the folding. Low selects horizontal folding, which is also the setting to use when no cartridge is present. High selects vertical folding. The palette window repeats every 32 bytes.

The request side uses valid/ready. The block never applies back-pressure: `req_ready` is high in every cycle after reset, so a request is taken in any cycle where `req_valid` is high. Read data comes back exactly one clock later with `rsp_valid`. The response side has no ready, and the consumer must take the data in that cycle.

Top module: `vmem_map`

## Requirements
- R1: While reset is held, `req_ready`, `rsp_valid` and `addr_err` are 0. From the first clock edge after reset, `req_ready` stays 1.
- R2: An accepted read gives `rsp_valid` high for exactly the next cycle, with the read data on `rsp_data`. An accepted write never produces `rsp_valid`.
- R3: A read below 0x2000 raises `chr_rd_en` in the request cycle, with `chr_addr` equal to the low 13 address bits. The byte that the ROM returns on `chr_data` in the next cycle becomes `rsp_data`. A write below 0x2000 does not raise `chr_rd_en` and stores nothing.
- R4: With `mirror_vert` = 0 (horizontal), windows 0x2000 and 0x2400 share physical table 0, and windows 0x2800 and 0x2C00 share physical table 1.
- R5: With `mirror_vert` = 1 (vertical), windows 0x2000 and 0x2800 share physical table 0, and windows 0x2400 and 0x2C00 share physical table 1.
- R6: Inside a physical table the byte offset is the address modulo 1024. Two window addresses that map to the same table and have equal low 10 bits access the same byte.
- R7: Reads in 0x3000–0x3EFF return 0. Writes there change no nametable or palette byte.
- R8: Addresses from 0x3F00 to 0x3FFF access palette entry (address − 0x3F00) mod 32, so addresses 32 apart alias.
- R9: Any request at 0x4000 or above raises `addr_err` in the following cycle. A read there returns 0, and a write there changes no stored byte.
- R10: `addr_err` is high only in the cycle right after an accepted request at 0x4000 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mirror_vert | input | 1 | Nametable folding: 0 horizontal, 1 vertical |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 16 | Video address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 8 | Read data |
| addr_err | output | 1 | Previous request was out of the 14-bit space |
| chr_rd_en | output | 1 | Character-ROM read strobe |
| chr_addr | output | 13 | Character-ROM address |
| chr_data | input | 8 | Character-ROM data, one cycle after the strobe |

## Verification
The hardest case to reach is aliasing under a mode change. A byte is stored through one logical window under one folding and then read back through another window under the other folding. The check then depends on every earlier write to both physical tables. To reach it, the bench first fills both tables and the palette through the ports. It then runs a long random mix of reads and writes over all regions, and at random points it flips `mirror_vert` between operations. A reference model tracks the contents of the physical tables. Directed cases add the region edges, and writes to the unused and out-of-range areas each followed by a read-back of the bytes they might have corrupted.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int CHR_AW    = 13;
  localparam int NT_BYTES  = 1024;
  localparam int PAL_BYTES = 32;
  localparam int NT_AW     = $clog2(NT_BYTES);
  localparam int PAL_AW    = $clog2(PAL_BYTES);

  localparam logic [ADDR_W-1:0] NT_BASE   = 16'h2000;
  localparam logic [ADDR_W-1:0] DEAD_BASE = 16'h3000;
  localparam logic [ADDR_W-1:0] PAL_BASE  = 16'h3F00;
  localparam logic [ADDR_W-1:0] TOP_LIMIT = 16'h4000;

  typedef enum logic [2:0] {
    TGT_CHR,
    TGT_NT,
    TGT_PAL,
    TGT_DEAD,
    TGT_ERR
  } vmem_tgt_e;
endpackage

// File: rtl/vmem_decode.sv
module vmem_decode
  import vmem_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              mirror_vert,
  output vmem_tgt_e         tgt,
  output logic              nt_sel,
  output logic [NT_AW-1:0]  nt_off,
  output logic [PAL_AW-1:0] pal_idx
);
  logic [1:0] window;

  always_comb begin
    if (addr >= TOP_LIMIT)       tgt = TGT_ERR;
    else if (addr < NT_BASE)     tgt = TGT_CHR;
    else if (addr < DEAD_BASE)   tgt = TGT_NT;
    else if (addr < PAL_BASE)    tgt = TGT_DEAD;
    else                         tgt = TGT_PAL;
  end

  // logical window inside the nametable region
  assign window  = addr[NT_AW+1:NT_AW];
  // horizontal folding pairs windows by the upper bit, vertical by the lower
  assign nt_sel  = mirror_vert ? window[0] : window[1];
  assign nt_off  = addr[NT_AW-1:0];
  // palette base is aligned to its size, so the low bits are the index
  assign pal_idx = addr[PAL_AW-1:0];
endmodule

// File: rtl/vmem_ram.sv
module vmem_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/vmem_map.sv
module vmem_map
  import vmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mirror_vert,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              addr_err,
  output logic              chr_rd_en,
  output logic [CHR_AW-1:0] chr_addr,
  input  logic [DATA_W-1:0] chr_data
);
  localparam int NT_COUNT = 2;

  vmem_tgt_e         tgt, tgt_q;
  logic              nt_sel, nt_sel_q;
  logic [NT_AW-1:0]  nt_off;
  logic [PAL_AW-1:0] pal_idx;
  logic              accept, rd_acc, wr_acc;
  logic [DATA_W-1:0] nt_q [NT_COUNT];
  logic [DATA_W-1:0] pal_q;

  assign accept = req_valid && req_ready;
  assign rd_acc = accept && !req_write;
  assign wr_acc = accept && req_write;

  vmem_decode u_decode (
    .addr        (req_addr),
    .mirror_vert (mirror_vert),
    .tgt         (tgt),
    .nt_sel      (nt_sel),
    .nt_off      (nt_off),
    .pal_idx     (pal_idx)
  );

  generate
    for (genvar g = 0; g < NT_COUNT; g++) begin : g_nt
      logic hit;
      assign hit = (tgt == TGT_NT) && (nt_sel == g[0]);
      vmem_ram #(.DEPTH(NT_BYTES), .WIDTH(DATA_W)) u_nt (
        .clk   (clk),
        .we    (wr_acc && hit),
        .re    (rd_acc && hit),
        .addr  (nt_off),
        .wdata (req_wdata),
        .rdata (nt_q[g])
      );
    end
  endgenerate

  vmem_ram #(.DEPTH(PAL_BYTES), .WIDTH(DATA_W)) u_pal (
    .clk   (clk),
    .we    (wr_acc && tgt == TGT_PAL),
    .re    (rd_acc && tgt == TGT_PAL),
    .addr  (pal_idx),
    .wdata (req_wdata),
    .rdata (pal_q)
  );

  // pattern reads leave on the ROM port in the request cycle
  assign chr_rd_en = rd_acc && (tgt == TGT_CHR);
  assign chr_addr  = req_addr[CHR_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      addr_err  <= 1'b0;
      tgt_q     <= TGT_DEAD;
      nt_sel_q  <= 1'b0;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= rd_acc;
      addr_err  <= accept && (tgt == TGT_ERR);
      if (rd_acc) begin
        tgt_q    <= tgt;
        nt_sel_q <= nt_sel;
      end
    end
  end

  always_comb begin
    unique case (tgt_q)
      TGT_CHR: rsp_data = chr_data;
      TGT_NT:  rsp_data = nt_q[nt_sel_q];
      TGT_PAL: rsp_data = pal_q;
      default: rsp_data = '0;
    endcase
  end
endmodule

// File: rtl/vmem_map_checks.sv
module vmem_map_checks
  import vmem_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              addr_err,
  input logic              chr_rd_en,
  input logic [CHR_AW-1:0] chr_addr
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid);

  assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc && !req_write));

  assert_chr_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chr_rd_en |-> (acc && !req_write && req_addr < NT_BASE
                   && chr_addr == req_addr[CHR_AW-1:0]));

  assert_dead_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr >= DEAD_BASE && req_addr < PAL_BASE)
      |=> (rsp_data == '0));

  assert_err_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_addr >= TOP_LIMIT) |=> addr_err);

  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && addr_err) |-> (rsp_data == '0));

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> $past(acc && req_addr >= TOP_LIMIT));
endmodule

bind vmem_map vmem_map_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .addr_err  (addr_err),
  .chr_rd_en (chr_rd_en),
  .chr_addr  (chr_addr)
);

// File: tb/vmem_map_bench.sv
module vmem_map_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mirror_vert = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        addr_err;
  logic        chr_rd_en;
  logic [12:0] chr_addr;
  logic [7:0]  chr_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] nt_m [2][1024];
  logic [7:0] pal_m [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  vmem_map u_vmem_map (
    .clk(clk), .rst_n(rst_n), .mirror_vert(mirror_vert),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .addr_err(addr_err),
    .chr_rd_en(chr_rd_en), .chr_addr(chr_addr), .chr_data(chr_data)
  );

  function automatic logic [7:0] chr_fn(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  // synchronous character ROM model
  always @(posedge clk) if (chr_rd_en) chr_data <= chr_fn(chr_addr);

  function automatic int phys(input logic [15:0] a, input logic mv);
    return mv ? int'(a[10]) : int'(a[11]);
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a, input logic mv);
    if (a >= 16'h4000) return 8'h00;
    if (a < 16'h2000)  return chr_fn(a[12:0]);
    if (a < 16'h3000)  return nt_m[phys(a, mv)][a[9:0]];
    if (a < 16'h3F00)  return 8'h00;
    return pal_m[a[4:0]];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic op(input bit wr, input logic [15:0] a, input logic [7:0] d,
                    input string req);
    logic [7:0] e;
    bit ce;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    e = exp_read(a, mirror_vert);
    #1;
    ce = !wr && a < 16'h2000;
    check(chr_rd_en == ce, "R3", "chr_rd_en", chr_rd_en, ce);
    if (ce) check(chr_addr == a[12:0], "R3", "chr_addr", chr_addr, a[12:0]);
    if (wr) begin
      if (a >= 16'h2000 && a < 16'h3000) nt_m[phys(a, mirror_vert)][a[9:0]] = d;
      else if (a >= 16'h3F00 && a < 16'h4000) pal_m[a[4:0]] = d;
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == !wr, "R2", "rsp_valid", rsp_valid, !wr);
    check(addr_err == (a >= 16'h4000), "R10", "addr_err", addr_err, a >= 16'h4000);
    if (!wr) check(rsp_data == e, req, "rsp_data", rsp_data, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250201));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 0 && rsp_valid == 0 && addr_err == 0, "R1", "reset outputs",
          {req_ready, rsp_valid, addr_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1, "R1", "req_ready", req_ready, 1);

    // fill both tables and the palette (horizontal folding)
    for (int i = 0; i < 1024; i++) begin
      op(1, 16'h2000 + 16'(i), 8'($urandom), "R4");
      op(1, 16'h2800 + 16'(i), 8'($urandom), "R4");
    end
    for (int i = 0; i < 32; i++) op(1, 16'h3F00 + 16'(i), 8'($urandom), "R8");

    // directed corners
    mirror_vert = 0;
    op(1, 16'h2407, 8'h5A, "R4"); op(0, 16'h2007, 0, "R4"); op(0, 16'h2C07, 0, "R4");
    mirror_vert = 1;
    op(1, 16'h2C10, 8'h3C, "R5"); op(0, 16'h2410, 0, "R5"); op(0, 16'h2010, 0, "R5");
    op(0, 16'h2BFF, 0, "R6"); op(0, 16'h23FF, 0, "R6"); op(0, 16'h2FFF, 0, "R6");
    op(1, 16'h3F05, 8'h77, "R8"); op(0, 16'h3FE5, 0, "R8"); op(0, 16'h3F25, 0, "R8");
    op(1, 16'h3123, 8'hEE, "R7"); op(0, 16'h2123, 0, "R7"); op(0, 16'h2523, 0, "R7");
    op(0, 16'h3F03, 0, "R7"); op(0, 16'h3000, 0, "R7"); op(0, 16'h3EFF, 0, "R7");
    op(1, 16'h1FFF, 8'h99, "R3"); op(0, 16'h1FFF, 0, "R3"); op(0, 16'h0000, 0, "R3");
    op(1, 16'h4000, 8'h11, "R9"); op(0, 16'h2000, 0, "R9"); op(0, 16'h3F00, 0, "R9");
    op(0, 16'h4000, 0, "R9"); op(0, 16'hFFFF, 0, "R9"); op(0, 16'h3FFF, 0, "R8");

    // random mix with mode flips
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      string rq;
      int b;
      if ($urandom % 16 == 0) mirror_vert = ~mirror_vert;
      b = $urandom % 6;
      case (b)
        0: begin a = 16'($urandom % 32'h2000); rq = "R3"; end
        1, 2: begin a = 16'h2000 + 16'($urandom % 32'h1000); rq = mirror_vert ? "R5" : "R4"; end
        3: begin a = 16'h3F00 + 16'($urandom % 32'h100); rq = "R8"; end
        4: begin a = 16'h3000 + 16'($urandom % 32'hF00); rq = "R7"; end
        default: begin a = 16'h4000 + 16'($urandom % 32'hC000); rq = "R9"; end
      endcase
      op(bit'($urandom % 2), a, 8'($urandom), rq);
    end
    finish_run();
  end
endmodule